// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block runs enhanced-parallel-port address and data cycles on an external byte bus on behalf of a host. A host access at offset 3 becomes an address cycle and one at offset 4 becomes a data cycle. A data access may be one, two or four bytes wide. A wide access is broken into byte cycles. Each byte cycle raises a strobe and holds it until the peripheral answers on its wait line. The strobe is then dropped for one cycle before the next byte.

A cycle runs only when the port's control register holds the single pattern allowed for its direction. A request outside that pattern is finished at once with no bus activity. If the peripheral does not answer within a set number of clocks, the access is abandoned and a sticky timeout flag is set. The host sees this flag in bit 0 of the status value that the block passes through. The host clears the flag by writing the status offset with bit 0 set.

The host hands over one request at a time through a request strobe. While the access is in progress, busy is held high. A one-cycle done pulse then carries the read data.

Top module: `epp_cycle_engine`

## Requirements
- R1: An accepted access at offset 3 produces byte cycles on `addr_strobe` only. One at offset 4 produces byte cycles on `data_strobe` only. The two strobes are never high together.
- R2: A write at offset 3 or 4 runs only when `port_ctrl & 8'h2F == 8'h04`. Otherwise the write completes with no strobe and no bus drive, and the timeout flag is unchanged.
- R3: A read at offset 3 or 4 runs only when `port_ctrl & 8'h2F == 8'h24`. Otherwise it completes with no strobe and returns all ones in the accessed bytes: `8'hFF` for one byte, `16'hFFFF` for two, `32'hFFFFFFFF` for four.
- R4: Each byte cycle holds its strobe high until `periph_wait` is seen high at a clock edge. It then drops the strobe for exactly one cycle. On a read, it captures `epp_bus_in` at the edge where the wait is seen.
- R5: A byte cycle whose strobe has been high for `WAIT_LIMIT` clocks without a wait aborts the access and sets the timeout flag. No further bytes run. On a read, the bytes that did not complete stay `8'hFF`.
- R6: `status_view` equals `periph_status` with bit 0 replaced by the timeout flag.
- R7: An accepted write at offset 1 with `host_wdata[0]=1` clears the timeout flag. With bit 0 clear, the flag is left as it is.
- R8: `host_size` selects the width of a data access: 0 for one byte, 1 for two, 2 for four. The bytes move least significant first, and byte k uses bits `8k+7:8k` of `host_wdata` or `host_rdata`. Offset 3 always moves one byte. Writes drive `epp_bus_out` with `epp_bus_oe` high for the whole byte cycle.
- R9: A request is accepted when `host_req` is high and `busy` is low. Busy is high from the next cycle until the cycle of the single `host_done` pulse, inclusive. Requests made while busy are ignored.
- R10: After reset, busy, done, both strobes, bus drive and the timeout flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Request strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 3 | Register offset of the access |
| host_size | input | 2 | Access width code |
| host_wdata | input | 32 | Write data, little-endian bytes |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with done |
| port_ctrl | input | 8 | Current control register value |
| periph_status | input | 8 | Status lines from the port |
| status_view | output | 8 | Status with the timeout flag merged in bit 0 |
| timeout_flag | output | 1 | Sticky timeout flag |
| addr_strobe | output | 1 | Address cycle strobe |
| data_strobe | output | 1 | Data cycle strobe |
| periph_wait | input | 1 | Peripheral handshake answer |
| epp_bus_out | output | 8 | Byte driven on writes |
| epp_bus_oe | output | 1 | Bus drive enable |
| epp_bus_in | input | 8 | Byte returned on reads |

## Verification
The bench targets several corner cases:
- The gating patterns, including control values whose bits outside the mask are set. A design that decoded the mask wrongly would run cycles it must drop, or drop cycles that are legal.
- A four-byte read that times out after its first byte. A design that ran on after the failure, or that did not preset the missing bytes to ones, would return the wrong word.
- A second request placed while an access is in progress. An engine that accepted it would put extra bytes on the bus.
- Status writes with bit 0 clear and then set. A design that cleared the flag on any status write would lose the timeout too early.

// File: rtl/epp_pkg.sv
// Shared constants and state type for the enhanced parallel port cycle engine.
// Assumes byte-wide peripheral bus and 8-bit control/status registers.
package epp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RELEASE = 2'd2,
        ST_DONE    = 2'd3
    } epp_state_e;

    localparam logic [7:0] CTRL_GATE_MASK  = 8'h2F;
    localparam logic [7:0] CTRL_WR_PATTERN = 8'h04;
    localparam logic [7:0] CTRL_RD_PATTERN = 8'h24;

    localparam logic [2:0] OFS_STATUS = 3'd1;
    localparam logic [2:0] OFS_ADDR   = 3'd3;
    localparam logic [2:0] OFS_DATA   = 3'd4;
endpackage

// File: rtl/epp_gate.sv
// Control-register gate: decides whether a write or a read cycle may run.
// Assumes port_ctrl is the live control register value; purely combinational.
module epp_gate
    import epp_pkg::*;
(
    input  logic [7:0] port_ctrl,
    output logic       wr_ok,
    output logic       rd_ok
);
    logic [7:0] masked;

    // Compare the handshake-relevant control bits against each direction's pattern.
    always_comb begin
        masked = port_ctrl & CTRL_GATE_MASK;
        wr_ok  = (masked == CTRL_WR_PATTERN);
        rd_ok  = (masked == CTRL_RD_PATTERN);
    end
endmodule

// File: rtl/epp_timeout_status.sv
// Sticky timeout flag and its merge into bit 0 of the status value.
// Assumes set and clear are never requested in the same cycle (the host is busy while cycles run).
module epp_timeout_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_flag,
    input  logic       clr_flag,
    input  logic [7:0] status_in,
    output logic [7:0] status_out,
    output logic       flag
);
    // Hold the flag until the host clears it; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (set_flag) flag <= 1'b1;
        else if (clr_flag) flag <= 1'b0;
    end

    // Replace status bit 0 with the flag.
    always_comb begin
        status_out = (status_in & 8'hFE) | {7'd0, flag};
    end

    AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_flag)); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !set_flag) |=> !flag); // R7
endmodule

// File: rtl/epp_sequencer.sv
// Byte-cycle sequencer: runs one strobe/wait handshake per byte, least significant first,
// aborts on a wait timeout and reports completion with a one-cycle done pulse.
// Assumes start is only raised while busy is low; start_ok already holds the gate result.
module epp_sequencer
    import epp_pkg::*;
#(
    parameter int MAX_BYTES  = 4,
    parameter int WAIT_LIMIT = 8,
    localparam int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int CNT_W     = $clog2(WAIT_LIMIT + 1),
    localparam int DATA_W    = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic              start_epp,
    input  logic              start_addr,
    input  logic              start_ok,
    input  logic [IDX_W-1:0]  start_last,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              periph_wait,
    input  logic [7:0]        bus_in,
    output logic              busy,
    output logic              done,
    output logic              addr_strobe,
    output logic              data_strobe,
    output logic [7:0]        bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout_set
);
    epp_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_q;
    logic [CNT_W-1:0]  cnt;
    logic              wr_q;
    logic              addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [7:0]        lane [MAX_BYTES];
    logic              capture;
    logic              strobe_on;

    // Decode the handshake events of the current byte cycle.
    always_comb begin
        strobe_on   = (state == ST_STROBE);
        capture     = strobe_on && periph_wait && !wr_q;
        timeout_set = strobe_on && !periph_wait && (cnt == CNT_W'(WAIT_LIMIT - 1));
    end

    // Main state machine: accept, strobe, release, next byte or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            last_q  <= '0;
            cnt     <= '0;
            wr_q    <= 1'b0;
            addr_q  <= 1'b0;
            wdata_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    idx     <= '0;
                    cnt     <= '0;
                    last_q  <= start_last;
                    wr_q    <= start_wr;
                    addr_q  <= start_addr;
                    wdata_q <= start_wdata;
                    state   <= (start_epp && start_ok) ? ST_STROBE : ST_DONE;
                end
                ST_STROBE: begin
                    if (periph_wait)      state <= ST_RELEASE;
                    else if (timeout_set) state <= ST_DONE;
                    else                  cnt   <= cnt + 1'b1;
                end
                ST_RELEASE: begin
                    if (idx == last_q) begin
                        state <= ST_DONE;
                    end else begin
                        idx   <= idx + 1'b1;
                        cnt   <= '0;
                        state <= ST_STROBE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-lane read data: preset to ones within the access width, then filled as bytes arrive.
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)                          lane[g] <= 8'hFF;
            else if (start && !busy && !start_wr) lane[g] <= (IDX_W'(g) <= start_last) ? 8'hFF : 8'h00;
            else if (capture && idx == IDX_W'(g)) lane[g] <= bus_in;
        end
        assign rdata[g*8 +: 8] = lane[g];
    end

    // Drive host and bus outputs from the state.
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        addr_strobe = strobe_on && addr_q;
        data_strobe = strobe_on && !addr_q;
        bus_oe      = wr_q && (state == ST_STROBE || state == ST_RELEASE);
        bus_out     = wdata_q[{idx, 3'b000} +: 8];
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_strobe && data_strobe)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_TIMEOUT_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_set |-> (addr_strobe || data_strobe)); // R5
    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && periph_wait) |=> !(addr_strobe || data_strobe)); // R4
endmodule

// File: rtl/epp_cycle_engine.sv
// Top of the enhanced parallel port cycle engine: decodes host requests, gates them on the
// control register, runs byte cycles through the sequencer and keeps the timeout flag.
// Assumes one request at a time; requests seen while busy are dropped.
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter int MAX_BYTES  = 4,
    parameter int WAIT_LIMIT = 8,
    localparam int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int DATA_W    = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [2:0]        host_ofs,
    input  logic [1:0]        host_size,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [7:0]        port_ctrl,
    input  logic [7:0]        periph_status,
    output logic [7:0]        status_view,
    output logic              timeout_flag,
    output logic              addr_strobe,
    output logic              data_strobe,
    input  logic              periph_wait,
    output logic [7:0]        epp_bus_out,
    output logic              epp_bus_oe,
    input  logic [7:0]        epp_bus_in
);
    logic             wr_ok, rd_ok;
    logic             accept;
    logic             is_addr, is_data;
    logic             gate_ok;
    logic             clr_req;
    logic             to_set;
    logic [IDX_W-1:0] last_idx;

    epp_gate u_gate (
        .port_ctrl (port_ctrl),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok)
    );

    // Decode the request: offset class, gate result, byte count and status clear.
    always_comb begin
        accept  = host_req && !host_busy;
        is_addr = (host_ofs == OFS_ADDR);
        is_data = (host_ofs == OFS_DATA);
        gate_ok = host_wr ? wr_ok : rd_ok;
        clr_req = accept && host_wr && (host_ofs == OFS_STATUS) && host_wdata[0];
        if (!is_data)             last_idx = '0;
        else if (host_size == 2'd0) last_idx = '0;
        else if (host_size == 2'd1) last_idx = IDX_W'(1);
        else                        last_idx = IDX_W'(MAX_BYTES - 1);
    end

    epp_sequencer #(
        .MAX_BYTES  (MAX_BYTES),
        .WAIT_LIMIT (WAIT_LIMIT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_wr    (host_wr),
        .start_epp   (is_addr || is_data),
        .start_addr  (is_addr),
        .start_ok    (gate_ok),
        .start_last  (last_idx),
        .start_wdata (host_wdata),
        .periph_wait (periph_wait),
        .bus_in      (epp_bus_in),
        .busy        (host_busy),
        .done        (host_done),
        .addr_strobe (addr_strobe),
        .data_strobe (data_strobe),
        .bus_out     (epp_bus_out),
        .bus_oe      (epp_bus_oe),
        .rdata       (host_rdata),
        .timeout_set (to_set)
    );

    epp_timeout_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_flag   (to_set),
        .clr_flag   (clr_req),
        .status_in  (periph_status),
        .status_out (status_view),
        .flag       (timeout_flag)
    );

    AST_WR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && host_wr && (is_addr || is_data) && !wr_ok) |=> !(addr_strobe || data_strobe || epp_bus_oe)); // R2
    AST_RD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !host_wr && (is_addr || is_data) && !rd_ok) |=> (host_done && !addr_strobe && !data_strobe)); // R3
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe || data_strobe) |-> host_busy); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!host_busy && !timeout_flag && !addr_strobe && !data_strobe)); // R10
endmodule

// File: tb/tb_epp_cycle_engine.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module tb_epp_cycle_engine;
    localparam int LIMIT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [2:0]  host_ofs = 3'd0;
    logic [1:0]  host_size = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic        host_busy, host_done;
    logic [31:0] host_rdata;
    logic [7:0]  port_ctrl = 8'h0C;
    logic [7:0]  periph_status = 8'h00;
    logic [7:0]  status_view;
    logic        timeout_flag, addr_strobe, data_strobe;
    logic        periph_wait = 1'b0;
    logic [7:0]  epp_bus_out;
    logic        epp_bus_oe;
    logic [7:0]  epp_bus_in;

    epp_cycle_engine #(.MAX_BYTES(4), .WAIT_LIMIT(LIMIT)) dut (.*);

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model (updated at posedge) ----------------
    int          m_phase = 0, m_idx = 0, m_last = 0, m_cnt = 0;
    bit          m_to = 0, m_wr = 0, m_addr = 0, live = 0;
    logic [31:0] m_rd = '1, m_wd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_to = 0; m_rd = '1; m_idx = 0; m_cnt = 0; m_wr = 0; m_addr = 0; live = 1;
        end else begin
            case (m_phase)
                0: if (host_req) begin
                    int nb;
                    bit ok;
                    if (host_ofs == 3'd1 && host_wr && host_wdata[0]) m_to = 0;
                    nb = (host_ofs == 3'd4) ? ((host_size == 0) ? 1 : (host_size == 1) ? 2 : 4) : 1;
                    ok = host_wr ? ((port_ctrl & 8'h2F) == 8'h04) : ((port_ctrl & 8'h2F) == 8'h24);
                    m_wr = host_wr; m_addr = (host_ofs == 3'd3); m_wd = host_wdata;
                    m_idx = 0; m_cnt = 0; m_last = nb - 1;
                    if (!host_wr) m_rd = (nb == 4) ? 32'hFFFFFFFF : (nb == 2) ? 32'h0000FFFF : 32'h000000FF;
                    m_phase = ((host_ofs == 3'd3 || host_ofs == 3'd4) && ok) ? 1 : 3;
                end
                1: begin
                    if (periph_wait) begin
                        if (!m_wr) m_rd[m_idx*8 +: 8] = epp_bus_in;
                        m_phase = 2;
                    end else if (m_cnt == LIMIT - 1) begin
                        m_to = 1; m_phase = 3;
                    end else m_cnt++;
                end
                2: if (m_idx == m_last) m_phase = 3; else begin m_idx++; m_cnt = 0; m_phase = 1; end
                default: m_phase = 0;
            endcase
        end
    end

    // ---------------- peripheral model and per-clock compare (negedge) ----------------
    int       delay = 0, budget = -1, s_cnt = 0;
    bit       last_oe = 0;
    logic [7:0] last_bus = 0;
    bit       last_addr = 0;
    logic [7:0] rd_q[$];
    logic [7:0] wr_log[$];
    bit       addr_log[$];

    assign epp_bus_in = (rd_q.size() != 0) ? rd_q[0] : 8'h00;

    always @(negedge clk) begin
        if (live) begin
            chk(host_busy == (m_phase != 0), "R9 busy", {31'd0, host_busy}, {31'd0, m_phase != 0});
            chk(host_done == (m_phase == 3), "R9 done", {31'd0, host_done}, {31'd0, m_phase == 3});
            chk(addr_strobe == (m_phase == 1 && m_addr), "R4 addr_strobe", {31'd0, addr_strobe}, {31'd0, m_phase == 1 && m_addr});
            chk(data_strobe == (m_phase == 1 && !m_addr), "R4 data_strobe", {31'd0, data_strobe}, {31'd0, m_phase == 1 && !m_addr});
            chk(timeout_flag == m_to, "R5 flag", {31'd0, timeout_flag}, {31'd0, m_to});
            chk(status_view == {periph_status[7:1], m_to}, "R6 status", {24'd0, status_view}, {24'd0, periph_status[7:1], m_to});
            chk(epp_bus_oe == (m_wr && (m_phase == 1 || m_phase == 2)), "R8 bus_oe", {31'd0, epp_bus_oe}, {31'd0, m_wr && (m_phase == 1 || m_phase == 2)});
            if (epp_bus_oe) chk(epp_bus_out == m_wd[m_idx*8 +: 8], "R8 bus_out", {24'd0, epp_bus_out}, {24'd0, m_wd[m_idx*8 +: 8]});
            if (host_done && !m_wr) chk(host_rdata == m_rd, "R8 rdata", host_rdata, m_rd);
        end
        // peripheral: answer after delay negedges of strobe while budget lasts
        if (addr_strobe || data_strobe) begin
            if (!periph_wait) begin
                if (budget != 0 && s_cnt >= delay) periph_wait = 1'b1;
                else s_cnt++;
            end
            last_oe = epp_bus_oe; last_bus = epp_bus_out; last_addr = addr_strobe;
        end else begin
            if (periph_wait) begin
                if (budget > 0) budget--;
                if (rd_q.size() != 0) void'(rd_q.pop_front());
                if (last_oe) wr_log.push_back(last_bus);
                addr_log.push_back(last_addr);
            end
            periph_wait = 1'b0;
            s_cnt = 0;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic fire(input bit wr, input logic [2:0] ofs, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_ofs = ofs; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [2:0] ofs, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        while (host_busy) @(negedge clk);
        fire(wr, ofs, sz, wd);
        while (!host_done) @(negedge clk);
        rd = host_rdata;
        @(negedge clk);
    endtask

    logic [31:0] r;

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!host_busy && !host_done && !addr_strobe && !data_strobe && !epp_bus_oe && !timeout_flag,
            "R10 reset", {26'd0, host_busy, host_done, addr_strobe, data_strobe, epp_bus_oe, timeout_flag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: address write at offset 3 uses the address strobe only
        port_ctrl = 8'h04; delay = 0;
        wr_log.delete(); addr_log.delete();
        access(1, 3'd3, 2'd2, 32'hDEADBE5A, r);
        chk(wr_log.size() == 1 && wr_log[0] == 8'h5A && addr_log[0] == 1, "R1 addr write",
            {24'd0, wr_log.size() ? wr_log[0] : 8'h00}, 32'h5A);

        // R8: four-byte data write, least significant byte first
        delay = 2; wr_log.delete(); addr_log.delete();
        access(1, 3'd4, 2'd2, 32'h11223344, r);
        chk(wr_log.size() == 4 && {wr_log[3], wr_log[2], wr_log[1], wr_log[0]} == 32'h11223344 && addr_log[0] == 0,
            "R8 word write order", wr_log.size() == 4 ? {wr_log[3], wr_log[2], wr_log[1], wr_log[0]} : 32'd0, 32'h11223344);

        // R8: two-byte read
        port_ctrl = 8'h24; delay = 1; rd_q = '{8'h7E, 8'h81};
        access(0, 3'd4, 2'd1, 32'd0, r);
        chk(r == 32'h0000817E, "R8 half read", r, 32'h0000817E);

        // R1: address read at offset 3
        rd_q = '{8'hC3}; addr_log.delete();
        access(0, 3'd3, 2'd0, 32'd0, r);
        chk(r == 32'h000000C3 && addr_log.size() == 1 && addr_log[0] == 1, "R1 addr read", r, 32'h000000C3);

        // R2: writes with the wrong control pattern are dropped
        wr_log.delete();
        access(1, 3'd4, 2'd0, 32'h000000AA, r);          // read pattern
        port_ctrl = 8'h05;
        access(1, 3'd3, 2'd0, 32'h000000BB, r);          // strobe bit set
        chk(wr_log.size() == 0, "R2 gated writes", wr_log.size(), 0);
        port_ctrl = 8'hD4;                               // bits outside mask ignored
        access(1, 3'd4, 2'd0, 32'h000000CC, r);
        chk(wr_log.size() == 1 && wr_log[0] == 8'hCC, "R2 mask outside bits", wr_log.size(), 1);

        // R3: reads with the wrong control pattern return ones
        port_ctrl = 8'h04;
        access(0, 3'd4, 2'd2, 32'd0, r);
        chk(r == 32'hFFFFFFFF, "R3 gated word read", r, 32'hFFFFFFFF);
        port_ctrl = 8'h26;
        access(0, 3'd4, 2'd1, 32'd0, r);
        chk(r == 32'h0000FFFF, "R3 gated half read", r, 32'h0000FFFF);

        // R5: no answer -> timeout, ones returned
        port_ctrl = 8'h24; budget = 0; rd_q.delete();
        access(0, 3'd4, 2'd2, 32'd0, r);
        chk(r == 32'hFFFFFFFF && timeout_flag, "R5 timeout read", r, 32'hFFFFFFFF);
        periph_status = 8'hFE; #1;
        chk(status_view == 8'hFF, "R6 merge set", status_view, 8'hFF);

        // R7: status write with bit 0 clear leaves the flag; with bit 0 set clears it
        access(1, 3'd1, 2'd0, 32'h000000FE, r);
        chk(timeout_flag == 1'b1, "R7 keep flag", timeout_flag, 1);
        access(1, 3'd1, 2'd0, 32'h00000001, r);
        chk(timeout_flag == 1'b0 && status_view == 8'hFE, "R7 clear flag", status_view, 8'hFE);

        // R5: timeout after the first byte of a word read
        budget = 1; delay = 0; rd_q = '{8'h3C, 8'h99};
        access(0, 3'd4, 2'd2, 32'd0, r);
        chk(r == 32'hFFFFFF3C && timeout_flag, "R5 partial read", r, 32'hFFFFFF3C);
        access(1, 3'd1, 2'd0, 32'h00000001, r);
        budget = -1; rd_q.delete();

        // R9: a request while busy is ignored
        port_ctrl = 8'h04; delay = 3; wr_log.delete(); addr_log.delete();
        fire(1, 3'd4, 2'd0, 32'h000000AA);
        fire(1, 3'd3, 2'd0, 32'h00000055);
        while (host_busy) @(negedge clk);
        @(negedge clk);
        chk(wr_log.size() == 1 && wr_log[0] == 8'hAA && addr_log[0] == 0, "R9 ignore while busy",
            wr_log.size(), 1);

        // R10: reset clears a set flag and an access in progress
        budget = 0; port_ctrl = 8'h24;
        fire(0, 3'd4, 2'd2, 32'd0);
        repeat (LIMIT + 4) @(negedge clk);
        chk(timeout_flag == 1'b1, "R5 flag before reset", timeout_flag, 1);
        fire(0, 3'd4, 2'd0, 32'd0);
        rst_n = 1'b0; live = 0;
        @(negedge clk); @(negedge clk);
        chk(!timeout_flag && !host_busy && !data_strobe, "R10 reset mid access",
            {29'd0, timeout_flag, host_busy, data_strobe}, 32'd0);
        rst_n = 1'b1; budget = -1;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule